// File: doc/BRIEF.md
# Selectable-Width TDM Serial Port

This block carries sample codes between a parallel core and two frame-synchronised serial lines. Each line has its own frame sync, its own programmable slot index and a shared bit clock. In every frame the block shifts one parallel code out of a serial output and assembles one code from a serial input, both inside the slot chosen by the index. The output enable is high only during that slot, so an external pad buffer can float the line the rest of the time.

The compressed-code line has slots of 4 or 8 bits, selected by a mode input. The linear line always uses 8-bit slots. In 8-bit mode the compressed line works in pairs of frames. The transmitted code is sent twice, once in each frame of the pair. The receiver expects every sample to arrive twice, keeps the copy from the first frame and discards the repeat.

Top module: `tdm_port`

## Requirements
- R1: A frame starts at a rising clock edge where the sync input is sampled high after being low. A sync held high for several clocks starts only one frame. With slot index s and slot width W, the slot covers bit periods s*W to s*W+W-1. Bit period 0 begins at the first rising edge after the frame-start edge.
- R2: With `cpx_wide`=0 the compressed line uses 4-bit slots. The transmitted bits are `cpx_tx_code[3:0]`. A received sample appears in `cpx_rx_code[3:0]`, with bits 7:4 at zero.
- R3: With `cpx_wide`=1 the compressed line uses 8-bit slots. The linear line always uses 8-bit slots, whatever the value of `cpx_wide`.
- R4: Serial data travels most significant bit first. Serial outputs change on the rising clock edge, and serial inputs are sampled on the falling clock edge.
- R5: Each output enable is high exactly during the bit periods of its slot. While the enable is low, the matching data output is 0.
- R6: The transmitted code is captured from the parallel input at the frame-start edge. A change of the parallel input later in the frame does not alter that frame's serial data.
- R7: In 8-bit mode the compressed line captures a new transmit code only at the start of the first frame of each pair. The second frame sends the same code again.
- R8: In 8-bit mode the compressed line reports a received sample only for the first frame of each pair. The sample in the second frame is ignored.
- R9: A change of `cpx_wide` makes the next frame the first frame of a pair.
- R10: At the rising edge after the falling edge that samples the last bit of a slot, the receive valid output goes high for exactly one cycle. In the same cycle the receive code output shows the sample, and it holds that value until the next reported sample.
- R11: If a new frame starts before the slot has been fully received, the partial sample is dropped and no valid pulse is produced for it. The new frame counts from zero.
- R12: After reset, and until the first frame start, all enables, data outputs and valid outputs are 0 and the receive codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock for both lines |
| rst_n | input | 1 | Synchronous reset, active low |
| cpx_wide | input | 1 | Compressed-line mode: 0 gives 4-bit slots, 1 gives 8-bit slots in frame pairs |
| cpx_fs | input | 1 | Compressed-line frame sync |
| cpx_slot | input | SLOT_W | Compressed-line slot index |
| cpx_tx_code | input | 8 | Parallel code to transmit on the compressed line |
| cpx_din | input | 1 | Compressed-line serial input |
| cpx_dout | output | 1 | Compressed-line serial output |
| cpx_oe | output | 1 | Compressed-line output enable |
| cpx_rx_code | output | 8 | Last sample received on the compressed line |
| cpx_rx_valid | output | 1 | One-cycle strobe for a new compressed-line sample |
| lin_fs | input | 1 | Linear-line frame sync |
| lin_slot | input | SLOT_W | Linear-line slot index |
| lin_tx_code | input | 8 | Parallel code to transmit on the linear line |
| lin_din | input | 1 | Linear-line serial input |
| lin_dout | output | 1 | Linear-line serial output |
| lin_oe | output | 1 | Linear-line output enable |
| lin_rx_code | output | 8 | Last sample received on the linear line |
| lin_rx_valid | output | 1 | One-cycle strobe for a new linear-line sample |

## Verification
The hardest state to reach from the ports is the frame-pair phase right after a mode change. Once the narrow mode has run an even number of frames, a free-running toggle and a toggle restarted by the change point to different frames. The stimulus therefore runs three wide frames, then two narrow frames, then two wide frames. It counts the valid pulses and compares each transmitted bit with the code captured in the first frame of the pair. Early syncs are produced by shortening the frame below the end of the slot, so the partial sample has to disappear without a strobe.

// File: rtl/tdm_pkg.sv
// Package: shared constants and helpers for the TDM serial port.
// Assumes codes are at most 8 bits wide and the narrow slot width is 4.
package tdm_pkg;
    localparam int CODE_W   = 8;
    localparam int NARROW_W = 4;
    localparam int BIDX_W   = $clog2(CODE_W);

    typedef logic [CODE_W-1:0] code_t;

    // Index of the first (most significant) bit sent in a slot.
    function automatic logic [BIDX_W-1:0] top_bit(input logic wide);
        return wide ? BIDX_W'(CODE_W - 1) : BIDX_W'(NARROW_W - 1);
    endfunction
endpackage

// File: rtl/tdm_frame_ctr.sv
// Frame counter: detects the frame-start edge of a sync input and counts
// bit periods from it. It decodes whether the next bit period lies in the
// programmed slot and which bit of the slot that is.
// Assumes the slot end stays below the saturating idle value of the count.
module tdm_frame_ctr
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fs,
    input  logic                wide,
    input  logic [SLOT_W-1:0]   slot,
    output logic                frame_start,
    output logic                in_slot,
    output logic [BIDX_W-1:0]   bit_idx,
    output logic                last_bit
);
    localparam int CNT_W = SLOT_W + BIDX_W + 1;
    localparam logic [CNT_W-1:0] CNT_IDLE = '1;

    logic              fs_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  slot_base;
    logic [CNT_W-1:0]  slot_len;
    logic [CNT_W-1:0]  rel;

    // Sync edge: a rising sync starts one frame however long it stays high.
    assign frame_start = fs && !fs_q;

    // Slot geometry for the current width.
    always_comb begin
        if (wide) begin
            slot_base = CNT_W'({slot, 3'b000});
            slot_len  = CNT_W'(CODE_W);
        end else begin
            slot_base = CNT_W'({slot, 2'b00});
            slot_len  = CNT_W'(NARROW_W);
        end
        rel      = cnt - slot_base;
        in_slot  = (cnt >= slot_base) && (rel < slot_len);
        bit_idx  = rel[BIDX_W-1:0];
        last_bit = (bit_idx == top_bit(wide));
    end

    // Bit-period counter: cleared at frame start, saturates when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
            cnt  <= CNT_IDLE;
        end else begin
            fs_q <= fs;
            if (frame_start) begin
                cnt <= '0;
            end else if (cnt != CNT_IDLE) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_lane.sv
// One serial line: transmits a latched code MSB first in its slot and
// assembles the received code. With HAS_PAIR set it also applies the
// two-frame repeat rule of the wide mode. Outputs change on the rising edge
// and the input is sampled on the falling edge.
// Assumes the mode input changes only between slots.
module tdm_lane
    import tdm_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter bit HAS_PAIR = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fs,
    input  logic                wide,
    input  logic [SLOT_W-1:0]   slot,
    input  code_t               tx_code,
    input  logic                din,
    output logic                dout,
    output logic                oe,
    output code_t               rx_code,
    output logic                rx_valid
);
    logic              frame_start;
    logic              in_slot;
    logic              last_bit;
    logic [BIDX_W-1:0] bit_idx;
    logic [BIDX_W-1:0] tx_sel;
    logic              latch_en;
    logic              rx_gate;
    logic              act_q;
    logic              last_q;
    code_t             hold_q;
    code_t             shift_q;

    tdm_frame_ctr #(.SLOT_W(SLOT_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs          (fs),
        .wide        (wide),
        .slot        (slot),
        .frame_start (frame_start),
        .in_slot     (in_slot),
        .bit_idx     (bit_idx),
        .last_bit    (last_bit)
    );

    generate
        if (HAS_PAIR) begin : g_pair
            logic wide_q;
            logic pend_q;
            logic second_q;
            logic next_second;

            // Phase of the frame that starts at this edge.
            assign next_second = (pend_q || (wide != wide_q)) ? 1'b0 : !second_q;
            assign latch_en    = frame_start && (!wide || !next_second);
            assign rx_gate     = !wide || !second_q;

            // Pair phase: alternates per frame, restarted by a mode change.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wide_q   <= 1'b0;
                    pend_q   <= 1'b0;
                    second_q <= 1'b1;
                end else begin
                    wide_q <= wide;
                    if (frame_start) begin
                        second_q <= next_second;
                        pend_q   <= 1'b0;
                    end else if (wide != wide_q) begin
                        pend_q <= 1'b1;
                    end
                end
            end
        end else begin : g_single
            assign latch_en = frame_start;
            assign rx_gate  = 1'b1;
        end
    endgenerate

    assign tx_sel = top_bit(wide) - bit_idx;
    assign oe     = act_q;

    // Transmit code latch at the start of a frame that sends a new sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (latch_en) begin
            hold_q <= tx_code;
        end
    end

    // Output stage: drives the slot bits and tracks the slot for the receiver.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            act_q  <= 1'b0;
            last_q <= 1'b0;
            dout   <= 1'b0;
        end else begin
            act_q  <= in_slot;
            last_q <= in_slot && last_bit;
            dout   <= in_slot && hold_q[tx_sel];
        end
    end

    // Receive shifter: samples the input on the falling edge inside the slot.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (act_q) begin
            shift_q <= {shift_q[CODE_W-2:0], din};
        end
    end

    // Receive output: reports a complete sample that the pair rule accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_code  <= '0;
        end else begin
            rx_valid <= act_q && last_q && rx_gate;
            if (act_q && last_q && rx_gate) begin
                rx_code <= wide ? shift_q : code_t'(shift_q[NARROW_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/tdm_port.sv
// TDM serial port top: one compressed line with a selectable 4/8-bit slot
// and frame-pair rule, and one linear line with a fixed 8-bit slot.
// Assumes both lines share one bit clock and that each has its own sync.
module tdm_port
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpx_wide,
    input  logic              cpx_fs,
    input  logic [SLOT_W-1:0] cpx_slot,
    input  logic [7:0]        cpx_tx_code,
    input  logic              cpx_din,
    output logic              cpx_dout,
    output logic              cpx_oe,
    output logic [7:0]        cpx_rx_code,
    output logic              cpx_rx_valid,
    input  logic              lin_fs,
    input  logic [SLOT_W-1:0] lin_slot,
    input  logic [7:0]        lin_tx_code,
    input  logic              lin_din,
    output logic              lin_dout,
    output logic              lin_oe,
    output logic [7:0]        lin_rx_code,
    output logic              lin_rx_valid
);
    tdm_lane #(.SLOT_W(SLOT_W), .HAS_PAIR(1'b1)) u_cpx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs       (cpx_fs),
        .wide     (cpx_wide),
        .slot     (cpx_slot),
        .tx_code  (cpx_tx_code),
        .din      (cpx_din),
        .dout     (cpx_dout),
        .oe       (cpx_oe),
        .rx_code  (cpx_rx_code),
        .rx_valid (cpx_rx_valid)
    );

    tdm_lane #(.SLOT_W(SLOT_W), .HAS_PAIR(1'b0)) u_lin (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs       (lin_fs),
        .wide     (1'b1),
        .slot     (lin_slot),
        .tx_code  (lin_tx_code),
        .din      (lin_din),
        .dout     (lin_dout),
        .oe       (lin_oe),
        .rx_code  (lin_rx_code),
        .rx_valid (lin_rx_valid)
    );
endmodule

// File: rtl/tdm_port_checker.sv
// Checker: port-level properties of the TDM serial port, bound to the top.
module tdm_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpx_wide,
    input logic       cpx_fs,
    input logic       cpx_dout,
    input logic       cpx_oe,
    input logic [7:0] cpx_rx_code,
    input logic       cpx_rx_valid,
    input logic       lin_fs,
    input logic       lin_dout,
    input logic       lin_oe,
    input logic       lin_rx_valid
);
    assert_cpx_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpx_oe |-> !cpx_dout);
    assert_lin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_oe |-> !lin_dout);
    assert_cpx_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpx_rx_valid |=> !cpx_rx_valid);
    assert_lin_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lin_rx_valid |=> !lin_rx_valid);
    assert_cpx_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpx_fs) |=> !cpx_oe);
    assert_lin_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lin_fs) |=> !lin_oe);
    assert_narrow_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpx_rx_valid && !$past(cpx_wide)) |-> (cpx_rx_code[7:4] == 4'd0));
endmodule

bind tdm_port tdm_port_checker u_tdm_port_checker (.*);

// File: tb/tdm_port_bench.sv
`timescale 1ns/1ps
// Bench: behavioural per-edge reference model of both lines, compared on
// every clock with the design outputs.
module tdm_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpx_wide = 1'b0;
    logic fs_i [2];
    logic din_i [2];
    logic [4:0] slot_i [2];
    logic [7:0] code_i [2];
    logic oe_o [2];
    logic dout_o [2];
    logic val_o [2];
    logic [7:0] rxc_o [2];

    int nchk = 0;
    int nerr = 0;
    string scen = "R12 reset";

    // reference model state, index 0 = compressed line, 1 = linear line
    int  pos [2];
    bit  fsprev [2];
    bit  wprev [2];
    bit  chg [2];
    bit  cur_first [2];
    logic [7:0] hold [2];
    bit  p_act [2];
    bit  p_din [2];
    int  acc [2];
    int  nbit [2];
    int  nvalid [2];
    bit  e_oe [2];
    bit  e_dout [2];
    bit  e_valid [2];
    logic [7:0] e_code [2];

    always #10 clk = ~clk;

    tdm_port u_tdm_port (
        .clk(clk), .rst_n(rst_n), .cpx_wide(cpx_wide),
        .cpx_fs(fs_i[0]), .cpx_slot(slot_i[0]), .cpx_tx_code(code_i[0]),
        .cpx_din(din_i[0]), .cpx_dout(dout_o[0]), .cpx_oe(oe_o[0]),
        .cpx_rx_code(rxc_o[0]), .cpx_rx_valid(val_o[0]),
        .lin_fs(fs_i[1]), .lin_slot(slot_i[1]), .lin_tx_code(code_i[1]),
        .lin_din(din_i[1]), .lin_dout(dout_o[1]), .lin_oe(oe_o[1]),
        .lin_rx_code(rxc_o[1]), .lin_rx_valid(val_o[1])
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, scen, act, exp, $time);
        end
    endtask

    task automatic model_edge(input int s);
        bit wide_now;
        bit sync;
        int w;
        int st;
        wide_now = (s == 0) ? cpx_wide : 1'b1;
        w = wide_now ? 8 : 4;
        e_valid[s] = 1'b0;
        if (p_act[s]) begin
            acc[s] = (acc[s] << 1) | int'(p_din[s]);
            nbit[s]++;
            if (nbit[s] == w) begin
                if (s == 1 || !wide_now || cur_first[s]) begin
                    e_valid[s] = 1'b1;
                    e_code[s] = 8'(acc[s]);
                    nvalid[s]++;
                end
                acc[s] = 0;
                nbit[s] = 0;
            end
        end
        if (wide_now != wprev[s]) chg[s] = 1'b1;
        wprev[s] = wide_now;
        sync = fs_i[s] && !fsprev[s];
        fsprev[s] = fs_i[s];
        if (sync) begin
            cur_first[s] = chg[s] || !cur_first[s];
            chg[s] = 1'b0;
            if (s == 1 || !wide_now || cur_first[s]) hold[s] = code_i[s];
            pos[s] = 0;
            acc[s] = 0;
            nbit[s] = 0;
            e_oe[s] = 1'b0;
            e_dout[s] = 1'b0;
            p_act[s] = 1'b0;
        end else if (pos[s] >= 0) begin
            st = int'(slot_i[s]) * w;
            if (pos[s] >= st && pos[s] < st + w) begin
                e_oe[s] = 1'b1;
                e_dout[s] = hold[s][w - 1 - (pos[s] - st)];
                p_act[s] = 1'b1;
            end else begin
                e_oe[s] = 1'b0;
                e_dout[s] = 1'b0;
                p_act[s] = 1'b0;
            end
            if (pos[s] < 100000) pos[s]++;
        end else begin
            e_oe[s] = 1'b0;
            e_dout[s] = 1'b0;
            p_act[s] = 1'b0;
        end
    endtask

    // Monitor: advance the model at each rising edge, compare away from it.
    always @(posedge clk) begin
        if (rst_n) begin
            model_edge(0);
            model_edge(1);
        end
        #3;
        for (int s = 0; s < 2; s++) begin
            chk(oe_o[s] === e_oe[s], "R1 R3 R5 enable", int'(oe_o[s]), int'(e_oe[s]));
            chk(dout_o[s] === e_dout[s], "R4 R6 R7 serial out", int'(dout_o[s]), int'(e_dout[s]));
            chk(val_o[s] === e_valid[s], "R8 R10 R11 valid", int'(val_o[s]), int'(e_valid[s]));
            chk(rxc_o[s] === e_code[s], "R2 R3 R10 rx code", int'(rxc_o[s]), int'(e_code[s]));
        end
    end

    // Serial input driver: random bits every period, recorded for the model.
    always @(posedge clk) begin
        #1;
        for (int s = 0; s < 2; s++) begin
            din_i[s] = 1'($urandom);
            p_din[s] = din_i[s];
        end
    end

    task automatic run_frames(input string tag, input int nf, input int len, input int fsw,
                              input int exp0, input int exp1);
        scen = tag;
        nvalid[0] = 0;
        nvalid[1] = 0;
        for (int f = 0; f < nf; f++) begin
            for (int c = 0; c < len; c++) begin
                @(posedge clk);
                #1;
                fs_i[0] = (c < fsw);
                fs_i[1] = (c < fsw);
                if (c == 2 || c == len / 2) begin
                    code_i[0] = 8'($urandom);
                    code_i[1] = 8'($urandom);
                end
            end
        end
        chk(nvalid[0] == exp0, "R8 R9 R11 compressed sample count", nvalid[0], exp0);
        chk(nvalid[1] == exp1, "R3 R11 linear sample count", nvalid[1], exp1);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        nerr++;
        $display("FAIL watchdog expired [%s]", scen);
        finish_up();
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            fs_i[s] = 1'b0; slot_i[s] = '0; code_i[s] = '0;
            pos[s] = -1; fsprev[s] = 1'b0; wprev[s] = 1'b0; chg[s] = 1'b0;
            cur_first[s] = 1'b0; hold[s] = '0; p_act[s] = 1'b0; acc[s] = 0;
            nbit[s] = 0; nvalid[s] = 0; e_oe[s] = 1'b0; e_dout[s] = 1'b0;
            e_valid[s] = 1'b0; e_code[s] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        scen = "R12 idle before first sync";
        repeat (6) @(posedge clk);
        #1;
        // R2: narrow slots at index 0
        slot_i[0] = 5'd0; slot_i[1] = 5'd0;
        run_frames("R2 narrow slot 0", 4, 16, 1, 4, 4);
        // R1: later slots, sync held for three clocks
        slot_i[0] = 5'd3; slot_i[1] = 5'd1;
        run_frames("R1 long sync, slots 3 and 1", 4, 24, 3, 4, 4);
        // R3 R7 R8: wide mode pairs
        cpx_wide = 1'b1; slot_i[0] = 5'd2; slot_i[1] = 5'd2;
        run_frames("R7 R8 wide pairs", 6, 32, 1, 3, 6);
        run_frames("R7 R8 odd wide run", 3, 32, 2, 2, 3);
        // R9: narrow for an even number of frames, then wide again
        cpx_wide = 1'b0;
        run_frames("R9 narrow gap", 2, 32, 1, 2, 2);
        cpx_wide = 1'b1;
        run_frames("R9 wide after change", 2, 32, 1, 1, 2);
        // R11: sync arrives before the slot ends
        cpx_wide = 1'b0; slot_i[0] = 5'd3; slot_i[1] = 5'd1;
        run_frames("R11 early sync", 3, 14, 1, 0, 0);
        run_frames("R11 recovery", 1, 20, 1, 1, 1);
        @(posedge clk);
        #5;
        finish_up();
    end
endmodule